// File: doc/BRIEF.md
# Serial Port FIFO Interrupt Logic

This block produces the interrupt conditions of a synchronous serial port whose frames pass through an 8-entry receive FIFO and an 8-entry transmit FIFO. The FIFOs are not part of the block. It sees only their occupancy levels, a strobe for each frame that arrives at the receive side, and a strobe for each read of the receive FIFO. From these inputs it builds four conditions and reports them three ways: as a raw status word, as a status word masked by an enable register, and as a single interrupt line.

Two of the conditions are sticky. The first is receive overrun: a frame arrived while the receive FIFO was full. The second is receive timeout: data has waited unread for 32 serial bit periods. Software clears each of these by writing a one to its bit in a clear port. The other two conditions follow the FIFO levels with no delay. One reports that the receive FIFO is at least half full. The other reports that the transmit FIFO is at least half empty.

The timeout uses the port's own bit rate. One bit period lasts `max(psc_div_i,1) * (rate_i + 1)` clock cycles. The same period applies in master and slave modes.

Top module: `spirq_top`

## Requirements
- R1: A cycle in which `rx_frame_i` is high while `rx_level_i` equals 8 sets raw bit 0 (overrun) at the next clock edge. The bit then stays set until it is cleared. A frame that arrives while the level is below 8 does not set it.
- R2: A cycle with `clr_we_i` high clears raw bit 0 when `clr_wdata_i[0]` is 1, and clears raw bit 1 when `clr_wdata_i[1]` is 1. A zero in either bit of `clr_wdata_i` leaves the matching status bit unchanged.
- R3: If a sticky bit's set event and its clear write happen in the same cycle, the bit is set after that edge.
- R4: Let D = max(`psc_div_i`,1)·(`rate_i`+1). Raw bit 1 (timeout) is set by the clock edge that ends the 32·D-th cycle after a restart, provided `rx_level_i` stayed nonzero and no further strobe came in those cycles. It is not set by the edge before that one.
- R5: A high `rx_frame_i` or `rx_read_i` restarts the timeout count. While `rx_level_i` is 0 the count is held at zero, so the timeout never sets while the receive FIFO is empty.
- R6: Raw bit 2 is 1 exactly while `rx_level_i` ≥ 4. Raw bit 3 is 1 exactly while `tx_level_i` ≤ 4. Both follow the levels in the same cycle and have no clear bit.
- R7: A cycle with `mask_we_i` high loads `mask_wdata_i[3:0]` into the enable mask. `masked_o` equals `raw_o` ANDed with the mask, bit for bit. Bits 31:4 of both `raw_o` and `masked_o` are always 0.
- R8: `irq_o` is the OR of all bits of `masked_o`.
- R9: Reset clears both sticky bits, the enable mask and the timeout count.
- R10: The timeout sets at most once per restart. After it is cleared, it does not set again until a new strobe restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_level_i | input | 4 | Receive FIFO occupancy, 0 to 8 |
| tx_level_i | input | 4 | Transmit FIFO occupancy, 0 to 8 |
| rx_frame_i | input | 1 | One-cycle strobe: a complete frame arrived |
| rx_read_i | input | 1 | One-cycle strobe: the receive FIFO was read |
| psc_div_i | input | 8 | Clock prescale divisor (0 acts as 1) |
| rate_i | input | 8 | Serial clock rate field; the divisor is rate_i+1 |
| mask_we_i | input | 1 | Write strobe for the enable mask |
| mask_wdata_i | input | 4 | New enable mask |
| clr_we_i | input | 1 | Write strobe for the clear port |
| clr_wdata_i | input | 2 | Write-one-to-clear bits: bit 0 overrun, bit 1 timeout |
| raw_o | output | 32 | Raw status: bit 0 overrun, 1 timeout, 2 receive half full, 3 transmit half empty |
| masked_o | output | 32 | Raw status ANDed with the enable mask |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that both level inputs stay within 0 to 8, and that each strobe lasts one cycle and describes the FIFO level presented in that same cycle. The bench drives the levels as a FIFO model would. It changes levels and strobes only on falling clock edges and never goes past the 8-entry depth. The timeout property assumes that a nonempty FIFO can lose its data only through a read strobe. The bench therefore lowers the receive level only in cycles that carry a read strobe, or when it moves to an empty FIFO on purpose.

// File: rtl/spirq_pkg.sv
package spirq_pkg;
  // status bit positions decoded by software
  localparam int unsigned ST_OVR  = 0;
  localparam int unsigned ST_TO   = 1;
  localparam int unsigned ST_RXL  = 2;
  localparam int unsigned ST_TXL  = 3;
  localparam int unsigned N_COND  = 4;
  localparam int unsigned N_STICK = 2;
endpackage

// File: rtl/spirq_rst_sync.sv
module spirq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/spirq_bit_timer.sv
module spirq_bit_timer #(
  parameter int unsigned PSCW    = 8,
  parameter int unsigned RATEW   = 8,
  parameter int unsigned TO_BITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             active_i,
  input  logic [PSCW-1:0]  psc_i,
  input  logic [RATEW-1:0] rate_i,
  output logic             fire_o
);
  localparam int unsigned BCW = $clog2(TO_BITS + 1);
  localparam logic [BCW-1:0]   B_DONE = BCW'(TO_BITS);
  localparam logic [BCW-1:0]   B_LAST = BCW'(TO_BITS - 1);
  localparam logic [BCW-1:0]   B_ONE  = BCW'(1);
  localparam logic [PSCW:0]    P_ONE  = (PSCW+1)'(1);
  localparam logic [PSCW-1:0]  P_INC  = PSCW'(1);
  localparam logic [RATEW-1:0] S_INC  = RATEW'(1);

  logic [PSCW-1:0]  pre_q, pre_d;
  logic [RATEW-1:0] sub_q, sub_d;
  logic [BCW-1:0]   bit_q, bit_d;
  logic             cnt_en;
  logic             pre_wrap, sub_wrap, done, tick;

  // prescale stage wraps after max(psc,1) cycles, rate stage after rate+1
  assign pre_wrap = ({1'b0, pre_q} + P_ONE) >= {1'b0, psc_i};
  assign sub_wrap = (sub_q == rate_i);
  assign done     = (bit_q == B_DONE);
  assign tick     = active_i && !restart_i && !done && pre_wrap && sub_wrap;
  assign fire_o   = tick && (bit_q == B_LAST);

  always_comb begin
    pre_d  = pre_q;
    sub_d  = sub_q;
    bit_d  = bit_q;
    cnt_en = 1'b0;
    if (restart_i || !active_i) begin
      cnt_en = 1'b1;
      pre_d  = '0;
      sub_d  = '0;
      bit_d  = '0;
    end else if (!done) begin
      cnt_en = 1'b1;
      pre_d  = pre_wrap ? '0 : pre_q + P_INC;
      if (pre_wrap) sub_d = sub_wrap ? '0 : sub_q + S_INC;
      if (tick)     bit_d = bit_q + B_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sub_q <= '0;
      bit_q <= '0;
    end else if (cnt_en) begin
      pre_q <= pre_d;
      sub_q <= sub_d;
      bit_q <= bit_d;
    end
  end
endmodule

// File: rtl/spirq_sticky.sv
module spirq_sticky #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_d;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic en;
    always_comb begin
      en     = set_i[g] || clr_i[g];
      q_d[g] = set_i[g];          // set has priority over clear
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_o[g] <= 1'b0;
      else if (en) q_o[g] <= q_d[g];
    end
  end
endmodule

// File: rtl/spirq_top.sv
module spirq_top
  import spirq_pkg::*;
#(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned PSCW    = 8,
  parameter int unsigned RATEW   = 8,
  parameter int unsigned TO_BITS = 32,
  parameter int unsigned SW      = 32,
  parameter int unsigned LVLW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic [LVLW-1:0]     rx_level_i,
  input  logic [LVLW-1:0]     tx_level_i,
  input  logic                rx_frame_i,
  input  logic                rx_read_i,
  input  logic [PSCW-1:0]     psc_div_i,
  input  logic [RATEW-1:0]    rate_i,
  input  logic                mask_we_i,
  input  logic [N_COND-1:0]   mask_wdata_i,
  input  logic                clr_we_i,
  input  logic [N_STICK-1:0]  clr_wdata_i,
  output logic [SW-1:0]       raw_o,
  output logic [SW-1:0]       masked_o,
  output logic                irq_o
);
  localparam logic [LVLW-1:0] LVL_FULL = LVLW'(DEPTH);
  localparam logic [LVLW-1:0] LVL_HALF = LVLW'(DEPTH / 2);

  logic                rst_sn;
  logic                rx_nonempty, restart, to_fire;
  logic [N_STICK-1:0]  stick_set, stick_clr, stick_q;
  logic [N_COND-1:0]   mask_q, mask_d, cond;

  spirq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_sn (rst_sn)
  );

  assign rx_nonempty = (rx_level_i != '0);
  assign restart     = rx_frame_i || rx_read_i;

  spirq_bit_timer #(
    .PSCW    (PSCW),
    .RATEW   (RATEW),
    .TO_BITS (TO_BITS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_sn),
    .restart_i (restart),
    .active_i  (rx_nonempty),
    .psc_i     (psc_div_i),
    .rate_i    (rate_i),
    .fire_o    (to_fire)
  );

  always_comb begin
    stick_set         = '0;
    stick_set[ST_OVR] = rx_frame_i && (rx_level_i == LVL_FULL);
    stick_set[ST_TO]  = to_fire;
    stick_clr         = clr_we_i ? clr_wdata_i : '0;
  end

  spirq_sticky #(.N(N_STICK)) u_sticky (
    .clk   (clk),
    .rst_n (rst_sn),
    .set_i (stick_set),
    .clr_i (stick_clr),
    .q_o   (stick_q)
  );

  // enable mask register
  assign mask_d = mask_wdata_i;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_d;
  end

  always_comb begin
    cond          = '0;
    cond[ST_OVR]  = stick_q[ST_OVR];
    cond[ST_TO]   = stick_q[ST_TO];
    cond[ST_RXL]  = (rx_level_i >= LVL_HALF);
    cond[ST_TXL]  = (tx_level_i <= LVL_HALF);
  end

  assign raw_o    = {{(SW-N_COND){1'b0}}, cond};
  assign masked_o = {{(SW-N_COND){1'b0}}, cond & mask_q};
  assign irq_o    = |(cond & mask_q);
endmodule

// File: rtl/spirq_chk.sv
module spirq_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SW    = 32,
  parameter int unsigned LVLW  = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [LVLW-1:0] rx_level_i,
  input logic [LVLW-1:0] tx_level_i,
  input logic            rx_frame_i,
  input logic            clr_we_i,
  input logic [1:0]      clr_wdata_i,
  input logic [SW-1:0]   raw_o,
  input logic [SW-1:0]   masked_o,
  input logic            irq_o
);
  localparam logic [LVLW-1:0] FULL = LVLW'(DEPTH);

  logic ovr_evt;
  assign ovr_evt = rx_frame_i && (rx_level_i == FULL);

  a_r1_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> raw_o[0]);

  a_r2_clear_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we_i && clr_wdata_i[0] && !ovr_evt) |=> !raw_o[0]);

  a_r2_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_o[0] && !(clr_we_i && clr_wdata_i[0])) |=> raw_o[0]);

  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && clr_we_i && clr_wdata_i[0]) |=> raw_o[0]);

  a_r5_no_timeout_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level_i == '0 && !raw_o[1]) |=> !raw_o[1]);

  a_r6_full_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level_i == FULL) |-> raw_o[2]);

  a_r6_empty_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level_i == '0) |-> raw_o[3]);

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_o[SW-1:4] == '0) && (masked_o[SW-1:4] == '0));

  a_r7_masked_subset: assert property (@(posedge clk) disable iff (!rst_n)
    (masked_o & ~raw_o) == '0);

  a_r8_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (masked_o != '0));
endmodule

bind spirq_top spirq_chk #(.DEPTH(DEPTH), .SW(SW), .LVLW(LVLW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sn),
  .rx_level_i  (rx_level_i),
  .tx_level_i  (tx_level_i),
  .rx_frame_i  (rx_frame_i),
  .clr_we_i    (clr_we_i),
  .clr_wdata_i (clr_wdata_i),
  .raw_o       (raw_o),
  .masked_o    (masked_o),
  .irq_o       (irq_o)
);

// File: tb/test_spirq_top.sv
module test_spirq_top;
  logic        clk;
  logic        arst_n;
  logic [3:0]  rx_level, tx_level;
  logic        rx_frame, rx_read;
  logic [7:0]  psc, rate;
  logic        mask_we, clr_we;
  logic [3:0]  mask_wdata;
  logic [1:0]  clr_wdata;
  logic [31:0] raw, masked;
  logic        irq;

  typedef struct {
    logic [3:0] raw;
    logic [3:0] msk;
    logic       irq;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  logic       exp_ovr = 1'b0, exp_to = 1'b0, to_evt = 1'b0;
  logic [3:0] exp_mask = 4'h0;

  spirq_top i_spirq_top (
    .clk(clk), .arst_n(arst_n), .rx_level_i(rx_level), .tx_level_i(tx_level),
    .rx_frame_i(rx_frame), .rx_read_i(rx_read), .psc_div_i(psc), .rate_i(rate),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata), .clr_we_i(clr_we),
    .clr_wdata_i(clr_wdata), .raw_o(raw), .masked_o(masked), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input logic [31:0] got, input logic [31:0] want, input string tag);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected outputs
  task automatic drive(input int rxl, input int txl, input bit frm, input bit rd,
                       input bit mwe, input logic [3:0] mdat,
                       input bit cwe, input logic [1:0] cdat, input string tag);
    item_t it;
    logic [3:0] r;
    @(negedge clk);
    rx_level = 4'(rxl); tx_level = 4'(txl);
    rx_frame = frm; rx_read = rd;
    mask_we = mwe; mask_wdata = mdat;
    clr_we = cwe; clr_wdata = cdat;
    if (frm && rxl == 8)      exp_ovr = 1'b1;
    else if (cwe && cdat[0])  exp_ovr = 1'b0;
    if (to_evt)               exp_to = 1'b1;
    else if (cwe && cdat[1])  exp_to = 1'b0;
    to_evt = 1'b0;
    if (mwe) exp_mask = mdat;
    r = {txl <= 4, rxl >= 4, exp_to, exp_ovr};
    it.raw = r; it.msk = r & exp_mask; it.irq = |(r & exp_mask); it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      rx_frame = 1'b0; rx_read = 1'b0; mask_we = 1'b0; clr_we = 1'b0;
    end
  endtask

  // R4/R5: restart, then look at the edges just before and at 32*D
  task automatic to_run(input int d, input bit by_read, input string tag);
    drive(1, 8, !by_read, by_read, 0, 4'h0, 0, 2'b00, {tag, " restart"});
    idle(32 * d - 2);
    drive(1, 8, 0, 0, 0, 4'h0, 0, 2'b00, {tag, " one edge early"});
    to_evt = 1'b1;
    drive(1, 8, 0, 0, 0, 4'h0, 0, 2'b00, {tag, " fires"});
  endtask

  // monitor: pops expectations mid-high phase after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        check(raw,   {28'h0, it.raw}, {it.tag, " raw"});
        check(masked, {28'h0, it.msk}, {it.tag, " masked"});
        check({31'h0, irq}, {31'h0, it.irq}, {it.tag, " irq"});
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    arst_n = 1'b0; rx_level = 4'd0; tx_level = 4'd8; rx_frame = 1'b0; rx_read = 1'b0;
    psc = 8'd200; rate = 8'd255; mask_we = 1'b0; mask_wdata = 4'h0;
    clr_we = 1'b0; clr_wdata = 2'b00;
    #55;
    check(raw, 32'h0, "R9 raw in reset");
    check({31'h0, irq}, 32'h0, "R9 irq in reset");
    @(negedge clk); arst_n = 1'b1;
    repeat (4) @(negedge clk);

    drive(0, 8, 0, 0, 0, 4'h0, 0, 2'b00, "R9 idle after reset");
    drive(4, 8, 0, 0, 0, 4'h0, 0, 2'b00, "R6 rx half full, R7 mask clear");
    drive(3, 4, 0, 0, 0, 4'h0, 0, 2'b00, "R6 tx half empty");
    drive(3, 5, 0, 0, 0, 4'h0, 0, 2'b00, "R6 tx above half");
    drive(8, 0, 0, 0, 1, 4'hF, 0, 2'b00, "R7 mask write all");
    drive(8, 0, 1, 0, 0, 4'h0, 0, 2'b00, "R1 overrun on full");
    drive(8, 0, 0, 0, 0, 4'h0, 0, 2'b00, "R1 overrun sticky");
    drive(7, 0, 0, 0, 0, 4'h0, 1, 2'b10, "R2 zero bit keeps overrun");
    drive(7, 0, 0, 0, 0, 4'h0, 1, 2'b01, "R2 clear overrun");
    drive(8, 0, 1, 0, 0, 4'h0, 1, 2'b01, "R3 set wins over clear");
    drive(7, 0, 0, 0, 0, 4'h0, 1, 2'b01, "R2 clear again");
    drive(7, 0, 1, 0, 0, 4'h0, 0, 2'b00, "R1 frame below full");
    drive(7, 8, 0, 0, 1, 4'b0001, 0, 2'b00, "R7 mask only overrun");
    drive(8, 8, 1, 0, 0, 4'h0, 0, 2'b00, "R8 irq from overrun");
    drive(5, 8, 0, 0, 0, 4'h0, 1, 2'b01, "R8 irq drops with rx level masked");
    drive(0, 8, 0, 0, 1, 4'hF, 1, 2'b11, "R7 mask all, prepare timeout");

    psc = 8'd2; rate = 8'd1;
    drive(0, 8, 0, 0, 0, 4'h0, 0, 2'b00, "R5 empty setup");
    to_run(4, 1'b0, "R4 frame D=4");
    drive(1, 8, 0, 0, 0, 4'h0, 1, 2'b10, "R2 clear timeout");
    idle(300);
    drive(1, 8, 0, 0, 0, 4'h0, 0, 2'b00, "R10 no second timeout");
    drive(1, 8, 1, 0, 0, 4'h0, 0, 2'b00, "R5 frame restart");
    idle(40);
    to_run(4, 1'b1, "R5 read restart D=4");
    drive(1, 8, 0, 0, 0, 4'h0, 1, 2'b10, "R2 clear timeout 2");
    psc = 8'd3; rate = 8'd2;
    to_run(9, 1'b0, "R4 frame D=9");
    drive(0, 8, 0, 0, 0, 4'h0, 1, 2'b10, "R5 go empty");
    psc = 8'd2; rate = 8'd1;
    idle(400);
    drive(0, 8, 0, 0, 0, 4'h0, 0, 2'b00, "R5 no timeout while empty");

    repeat (3) @(posedge clk);
    #6;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule